// File: doc/BRIEF.md
# Video Pixel Shift Register

This block turns one byte of display data into a serial stream of pixels. On each rising clock edge the register takes exactly one action: it clears, fills with a solid cursor pattern, loads a fresh byte either as given or inverted for reverse video, or moves every bit one place toward the least significant end. The pixel on screen at any moment is bit 0 of the register. A byte loaded into the register therefore leaves it in the order bit 0, bit 1, up to bit 7, and zeros follow once the byte has gone.

Load and reset are active-low inputs. Reset is synchronous and overrides everything else. The cursor input comes next in priority and masks both loading and shifting. A typical display pipeline pulses load once per character cell and lets the register shift for the remaining pixel clocks. It holds cursor high for the cells that show the cursor block.

Top module: `pixel_shifter`

## Requirements
- R1: When `rst_n` is 0 at a rising edge, all bits of `q` are 0 after that edge, whatever `load_n`, `rev` and `cur` are.
- R2: When `rst_n` is 1 and `cur` is 1 at a rising edge, all bits of `q` are 1 after that edge, whatever `load_n` and `rev` are.
- R3: When `rst_n` is 1, `cur` is 0, `load_n` is 0 and `rev` is 0 at a rising edge, `q` equals `din` after that edge (bit i of `q` takes bit i of `din`).
- R4: When `rst_n` is 1, `cur` is 0, `load_n` is 0 and `rev` is 1 at a rising edge, `q` equals the bitwise complement of `din` after that edge.
- R5: When `rst_n` is 1, `cur` is 0 and `load_n` is 1 at a rising edge, bit i of `q` takes the previous bit i+1 for i from 0 to 6, and bit 7 takes 0.
- R6: `rev` has no effect on `q` when the register is shifting or showing the cursor.
- R7: After a load, `q[0]` presents the loaded pixels in the order bit 0, bit 1, up to bit 7 on successive shift cycles, and `q` is all zero after eight shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Parallel load request, active low |
| rev | input | 1 | Reverse video: load the complement of `din` |
| cur | input | 1 | Cursor: fill the register with ones |
| din | input | 8 | Byte of pixel data |
| q | output | 8 | Register contents; `q[0]` is the current pixel |

## Verification
The bench goes after the priority corners: reset while cursor and load are both active, and cursor while load is active. A design with the wrong order would show ones or the data byte instead of zeros, or the data instead of the solid block. It shifts with `rev` held high, where a design that leaked reverse video into the shift path would invert the stream. It also runs a loaded byte out to empty. A wrong fill bit or a shift in the wrong direction would show stale ones or the pixels in mirrored order. Long random mixes of all four controls are compared against an independent model after every edge.

// File: rtl/pixel_shifter_pkg.sv
package pixel_shifter_pkg;

  // One action per clock edge; reset is handled apart from these.
  typedef enum logic [1:0] {
    ACT_SHIFT   = 2'd0,
    ACT_LOAD    = 2'd1,
    ACT_LOADINV = 2'd2,
    ACT_CURSOR  = 2'd3
  } act_e;

endpackage

// File: rtl/pixel_shifter_ctrl.sv
module pixel_shifter_ctrl
  import pixel_shifter_pkg::*;
(
  input  logic load_n,
  input  logic rev,
  input  logic cur,
  output act_e act
);

  // Cursor outranks load; load outranks shift.
  always_comb begin
    if (cur)          act = ACT_CURSOR;
    else if (!load_n) act = rev ? ACT_LOADINV : ACT_LOAD;
    else              act = ACT_SHIFT;
  end

endmodule

// File: rtl/pixel_shifter_core.sv
module pixel_shifter_core
  import pixel_shifter_pkg::*;
#(
  parameter int           WIDTH    = 8,
  parameter logic [WIDTH-1:0] CUR_PAT = '1,
  parameter logic         FILL_BIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_up;
    if (i == MSB) begin : g_top
      assign from_up = FILL_BIT;
    end else begin : g_mid
      assign from_up = q[i+1];
    end

    always_comb begin
      unique case (act)
        ACT_CURSOR:  nxt[i] = CUR_PAT[i];
        ACT_LOAD:    nxt[i] = din[i];
        ACT_LOADINV: nxt[i] = ~din[i];
        default:     nxt[i] = from_up;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R1
  clear_on_reset_chk: assert property (@(posedge clk)
    !rst_n |=> q == '0);

  // R2
  cursor_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_CURSOR |=> q == CUR_PAT);

  // R3
  load_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_LOAD |=> q == $past(din));

  // R4
  load_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_LOADINV |=> q == ~$past(din));

  // R5
  shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_SHIFT |=> q == {FILL_BIT, $past(q[MSB:1])});

endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter
  import pixel_shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             rev,
  input  logic             cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  act_e act;

  pixel_shifter_ctrl u_ctrl (
    .load_n (load_n),
    .rev    (rev),
    .cur    (cur),
    .act    (act)
  );

  pixel_shifter_core #(
    .WIDTH    (WIDTH),
    .CUR_PAT  ({WIDTH{1'b1}}),
    .FILL_BIT (1'b0)
  ) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .din   (din),
    .q     (q)
  );

  // R6: with reverse video high and no load, the stream must not invert
  rev_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rev && load_n && !cur) |=> q == {1'b0, $past(q[WIDTH-1:1])});

endmodule

// File: tb/test_pixel_shifter.sv
module test_pixel_shifter;

  localparam int  W      = 8;
  localparam time CLK_PER = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic         rev = 1'b0;
  logic         cur = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;

  pixel_shifter #(.WIDTH(W)) i_pixel_shifter (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .rev(rev),
    .cur(cur), .din(din), .q(q)
  );

  always #(CLK_PER/2) clk = ~clk;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  logic [W-1:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Driver: set inputs away from the edge and push the expected result.
  task automatic step(input logic r_n, input logic l_n, input logic rv,
                      input logic cu, input logic [W-1:0] d, input string tag);
    logic [W-1:0] e;
    @(negedge clk);
    rst_n = r_n; load_n = l_n; rev = rv; cur = cu; din = d;
    if (!r_n)      e = '0;
    else if (cu)   e = '1;
    else if (!l_n) e = rv ? ~d : d;
    else           e = {1'b0, model[W-1:1]};
    model = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (q !== e) begin
        errors++;
        $display("FAIL %s: q=%h expected %h", t, q, e);
      end
    end
  end

  initial begin
    // R1 reset state
    step(0, 1, 0, 0, 8'h00, "R1 reset");
    step(0, 0, 1, 1, 8'hA5, "R1 reset beats cursor and load");
    // R3 plain load, then R7 pixel order through eight shifts
    step(1, 0, 0, 0, 8'h96, "R3 load");
    for (int k = 0; k < 8; k++) step(1, 1, 0, 0, 8'hFF, "R7 pixel order");
    // R4 inverted load, R5 shifts
    step(1, 0, 1, 0, 8'h3C, "R4 inverted load");
    step(1, 1, 0, 0, 8'h00, "R5 shift");
    step(1, 1, 0, 0, 8'h00, "R5 shift");
    // R2 cursor overrides load and shift
    step(1, 0, 0, 1, 8'h12, "R2 cursor over load");
    step(1, 1, 1, 1, 8'h00, "R2 cursor over shift");
    // R6 rev ignored while shifting
    for (int k = 0; k < 4; k++) step(1, 1, 1, 0, 8'h55, "R6 rev during shift");
    step(1, 0, 1, 0, 8'h01, "R4 inverted load");
    step(1, 1, 1, 0, 8'h00, "R6 rev during shift");
    step(1, 0, 0, 0, 8'hFF, "R3 load all ones");
    step(0, 1, 0, 0, 8'h00, "R1 reset clears");
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] c;
      c = 4'($urandom);
      step(($urandom % 16) != 0, c[0], c[1], (c[3:2] == 2'b11),
           8'($urandom), "R1-R6 random mix");
    end
    step(1, 1, 0, 0, 8'h00, "R5 shift");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule